// File: doc/BRIEF.md
# Key Stage Sequencer

This block is the control core of a layered key manager. Software advances it one stage at a time through a fixed chain: an initial reset stage, then the creator root key, the owner intermediate key, the owner root key, and finally a terminal disabled stage. Each advance sends material to an external hash engine over a request/response handshake. The returned digest becomes the key of the next stage. The first advance hashes the root material input, which packs the device identity, the seeds and the boot digest.

In any operational stage, a generate command produces either an identity output or a software output. A one-bit command field selects the attestation CDI or the sealing CDI. The generate command hashes the current key with a salt and leaves the stage key unchanged. Every finished command pulses a done interrupt and updates a two-bit status. An escalation input sends the block to the disabled stage at any time. On that transition the key is overwritten with entropy. After that, generate outputs carry entropy rather than key material.

A sideload port presents the current key to one of three consumers: a hash engine, a block cipher or a big-number accelerator. A destination field picks the consumer.

Top module: `key_stage_ctrl`

## Requirements
- R1: After reset the outputs are as follows: stage_o is 0 (reset stage), status_o is 0 (idle), op_done_o is 0, hash_req_o is 0 and sl_valid_o is all zeros.
- R2: Stage codes are 0 reset, 1 creator root, 2 owner intermediate, 3 owner root, 4 disabled. Each successful advance (cmd_op_i=0) moves exactly one code forward. The key becomes the digest, except when the advance enters the disabled stage; then the key becomes entropy_i.
- R3: An accepted command raises hash_req_o in the next cycle. hash_req_o and hash_data_o then hold until hash_valid_i is seen, and hash_req_o drops in the cycle after that. hash_data_o is root_i for an advance from the reset stage. For every other command it is key XOR the byte {stage[2:0], op[1:0], cdi, 2'b01} repeated across the width.
- R4: status_o reads 1 (busy) after an accepted command. On completion it reads 2 (success) and op_done_o is high for exactly that one cycle.
- R5: Generate commands use cmd_op_i=1 for an identity output (ident_out_o) and cmd_op_i=2 for a software output (sw_out_o). cmd_cdi_i=0 selects attestation and 1 selects sealing. The chosen output takes the digest, and neither the stage nor the key changes.
- R6: A cycle with escalate_i high puts the block in the disabled stage after the next edge, whatever its stage. If the block was not already disabled, the key is overwritten with entropy_i. An operation in flight is aborted with op_done_o pulsed and status_o=3, and a digest that arrives later is ignored.
- R7: In the disabled stage, generate commands still run through the hash handshake and complete with success. Their output is entropy_i sampled at completion, which is neither all zeros, nor all ones, nor any stage key.
- R8: A command presented while an operation is in flight is rejected. op_done_o pulses with status_o=3, the stage is unchanged and the running operation still completes.
- R9: The following commands return status 3 with an op_done_o pulse, issue no hash request and leave the stage unchanged: an advance in the disabled stage, a generate in the reset stage, and op code 3.
- R10: sl_dest_i selects the consumer: 0 hash, 1 cipher, 2 big-number, 3 none. In stages 1 to 3, sl_valid_o is one-hot at the selected bit and sl_key_o equals the key. In the reset and disabled stages, or with no consumer selected, sl_valid_o is 0 and sl_key_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 2 | 0 advance, 1 identity, 2 software, 3 invalid |
| cmd_cdi_i | input | 1 | 0 attestation, 1 sealing |
| root_i | input | KEY_W | Packed root material for the first advance |
| escalate_i | input | 1 | Lifecycle escalation |
| entropy_i | input | KEY_W | Entropy used for wiping |
| hash_req_o | output | 1 | Request to the hash engine |
| hash_data_o | output | KEY_W | Data to hash |
| hash_valid_i | input | 1 | Digest valid |
| hash_digest_i | input | KEY_W | Returned digest |
| status_o | output | 2 | 0 idle, 1 busy, 2 success, 3 error |
| op_done_o | output | 1 | Done interrupt pulse |
| stage_o | output | 3 | Current stage code |
| ident_out_o | output | KEY_W | Identity output |
| sw_out_o | output | KEY_W | Software output |
| sl_dest_i | input | DEST_W | Sideload consumer select |
| sl_valid_o | output | NUM_DEST | Per-consumer sideload valid |
| sl_key_o | output | KEY_W | Sideload key |

## Verification
The bench sweeps both generate kinds and both CDIs in every operational stage. Because the salt differs per combination, a wrong stage, op or CDI field shows up as a different hash_data_o. Digest latency varies from zero to three cycles, which separates a design that waits for hash_valid_i from one that assumes a fixed delay. Escalation is applied from each of the four non-terminal stages and once mid-operation, which shows that the wipe and the abort do not depend on the stage. Illegal and overlapping commands are interleaved with legal ones to show that errors leave the stage and the key untouched.

// File: rtl/key_stage_pkg.sv
package key_stage_pkg;
  typedef enum logic [2:0] {
    STG_RESET      = 3'd0,
    STG_CREATOR    = 3'd1,
    STG_OWNER_INT  = 3'd2,
    STG_OWNER_ROOT = 3'd3,
    STG_DISABLED   = 3'd4
  } stage_e;

  typedef enum logic [1:0] {
    OP_ADVANCE = 2'd0,
    OP_GEN_ID  = 2'd1,
    OP_GEN_SW  = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_OK   = 2'd2,
    ST_ERR  = 2'd3
  } status_e;

  function automatic logic [7:0] salt_byte(stage_e s, op_e o, logic cdi);
    return {s, o, cdi, 2'b01};
  endfunction
endpackage

// File: rtl/ks_cmd_ctrl.sv
module ks_cmd_ctrl
  import key_stage_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    cmd_valid_i,
  input  op_e     cmd_op_i,
  input  logic    cmd_cdi_i,
  input  stage_e  stage_i,
  input  logic    escalate_i,
  input  logic    hash_valid_i,
  output logic    accept_o,
  output logic    complete_o,
  output op_e     op_q_o,
  output logic    cdi_q_o,
  output logic    hash_req_o,
  output status_e status_o,
  output logic    op_done_o
);
  logic    busy_q;
  logic    legal, reject, abort;
  status_e status_q;
  logic    done_q;
  op_e     op_q;
  logic    cdi_q;

  always_comb begin
    unique case (cmd_op_i)
      OP_ADVANCE: legal = (stage_i != STG_DISABLED);
      OP_GEN_ID,
      OP_GEN_SW:  legal = (stage_i != STG_RESET);
      default:    legal = 1'b0;
    endcase
  end

  assign accept_o   = cmd_valid_i && !busy_q && !escalate_i && legal;
  assign complete_o = busy_q && hash_valid_i && !escalate_i;
  assign abort      = busy_q && escalate_i;
  // a command arriving alongside the digest is dropped
  assign reject     = cmd_valid_i && !escalate_i && (busy_q ? !hash_valid_i : !legal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      status_q <= ST_IDLE;
      done_q   <= 1'b0;
      op_q     <= OP_ADVANCE;
      cdi_q    <= 1'b0;
    end else begin
      if (accept_o)                busy_q <= 1'b1;
      else if (complete_o || abort) busy_q <= 1'b0;

      if (complete_o)            status_q <= ST_OK;
      else if (abort || reject)  status_q <= ST_ERR;
      else if (accept_o)         status_q <= ST_BUSY;

      done_q <= complete_o || abort || reject;

      if (accept_o) begin
        op_q  <= cmd_op_i;
        cdi_q <= cmd_cdi_i;
      end
    end
  end

  assign op_q_o     = op_q;
  assign cdi_q_o    = cdi_q;
  assign hash_req_o = busy_q;
  assign status_o   = status_q;
  assign op_done_o  = done_q;

  assert_req_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && !hash_valid_i && !escalate_i |=> hash_req_o);
  assert_req_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && hash_valid_i |=> !hash_req_o);
  assert_ok_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && hash_valid_i && !escalate_i |=> op_done_o && status_o == ST_OK);
  assert_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && escalate_i |=> op_done_o && status_o == ST_ERR && !hash_req_o);
endmodule

// File: rtl/ks_key_stage.sv
module ks_key_stage
  import key_stage_pkg::*;
#(
  parameter int KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  op_e              cmd_op_i,
  input  logic             cmd_cdi_i,
  input  logic             complete_i,
  input  op_e              op_q_i,
  input  logic             escalate_i,
  input  logic [KEY_W-1:0] root_i,
  input  logic [KEY_W-1:0] digest_i,
  input  logic [KEY_W-1:0] entropy_i,
  output stage_e           stage_o,
  output logic [KEY_W-1:0] key_o,
  output logic [KEY_W-1:0] hash_data_o
);
  localparam int SALT_REP = KEY_W / 8;

  stage_e           stage_q, stage_d;
  logic [KEY_W-1:0] key_q, key_d;
  logic [KEY_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (accept_i) begin
      if (cmd_op_i == OP_ADVANCE && stage_q == STG_RESET) data_d = root_i;
      else data_d = key_q ^ {SALT_REP{salt_byte(stage_q, cmd_op_i, cmd_cdi_i)}};
    end
  end

  always_comb begin
    stage_d = stage_q;
    key_d   = key_q;
    if (escalate_i) begin
      if (stage_q != STG_DISABLED) begin
        stage_d = STG_DISABLED;
        key_d   = entropy_i;
      end
    end else if (complete_i && op_q_i == OP_ADVANCE) begin
      stage_d = stage_e'(3'(stage_q + 3'd1));
      key_d   = (stage_d == STG_DISABLED) ? entropy_i : digest_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= STG_RESET;
      key_q   <= '0;
      data_q  <= '0;
    end else begin
      stage_q <= stage_d;
      key_q   <= key_d;
      data_q  <= data_d;
    end
  end

  assign stage_o     = stage_q;
  assign key_o       = key_q;
  assign hash_data_o = data_q;

  assert_stage_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_q != $past(stage_q)) |->
      (stage_q == STG_DISABLED || 3'(stage_q) == 3'($past(stage_q) + 3'd1)));
  assert_escalate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    escalate_i |=> stage_q == STG_DISABLED);
endmodule

// File: rtl/ks_gen_out.sv
module ks_gen_out
  import key_stage_pkg::*;
#(
  parameter int KEY_W = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             complete_i,
  input  op_e              op_q_i,
  input  stage_e           stage_i,
  input  logic [KEY_W-1:0] digest_i,
  input  logic [KEY_W-1:0] entropy_i,
  output logic [KEY_W-1:0] ident_o,
  output logic [KEY_W-1:0] sw_o
);
  logic [KEY_W-1:0] ident_q, sw_q, value;

  assign value = (stage_i == STG_DISABLED) ? entropy_i : digest_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ident_q <= '0;
      sw_q    <= '0;
    end else if (complete_i) begin
      if (op_q_i == OP_GEN_ID) ident_q <= value;
      if (op_q_i == OP_GEN_SW) sw_q    <= value;
    end
  end

  assign ident_o = ident_q;
  assign sw_o    = sw_q;

  assert_gen_entropy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete_i && op_q_i == OP_GEN_SW && stage_i == STG_DISABLED
      |=> sw_o == $past(entropy_i));
endmodule

// File: rtl/ks_sideload.sv
module ks_sideload
  import key_stage_pkg::*;
#(
  parameter int KEY_W    = 256,
  parameter int NUM_DEST = 3,
  parameter int DEST_W   = 2
) (
  input  stage_e            stage_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [DEST_W-1:0] dest_i,
  output logic [NUM_DEST-1:0] valid_o,
  output logic [KEY_W-1:0]  key_o
);
  logic live, hit;

  assign live = (stage_i != STG_RESET) && (stage_i != STG_DISABLED);
  assign hit  = live && (int'(dest_i) < NUM_DEST);

  for (genvar d = 0; d < NUM_DEST; d++) begin : g_dest
    assign valid_o[d] = live && (dest_i == DEST_W'(d));
  end

  assign key_o = hit ? key_i : '0;
endmodule

// File: rtl/key_stage_ctrl.sv
module key_stage_ctrl
  import key_stage_pkg::*;
#(
  parameter int KEY_W    = 256,
  parameter int NUM_DEST = 3,
  parameter int DEST_W   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [1:0]          cmd_op_i,
  input  logic                cmd_cdi_i,
  input  logic [KEY_W-1:0]    root_i,
  input  logic                escalate_i,
  input  logic [KEY_W-1:0]    entropy_i,
  output logic                hash_req_o,
  output logic [KEY_W-1:0]    hash_data_o,
  input  logic                hash_valid_i,
  input  logic [KEY_W-1:0]    hash_digest_i,
  output logic [1:0]          status_o,
  output logic                op_done_o,
  output logic [2:0]          stage_o,
  output logic [KEY_W-1:0]    ident_out_o,
  output logic [KEY_W-1:0]    sw_out_o,
  input  logic [DEST_W-1:0]   sl_dest_i,
  output logic [NUM_DEST-1:0] sl_valid_o,
  output logic [KEY_W-1:0]    sl_key_o
);
  logic             accept, complete, cdi_q;
  op_e              op_q;
  status_e          status;
  stage_e           stage;
  logic [KEY_W-1:0] key;

  ks_cmd_ctrl i_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (op_e'(cmd_op_i)),
    .cmd_cdi_i    (cmd_cdi_i),
    .stage_i      (stage),
    .escalate_i   (escalate_i),
    .hash_valid_i (hash_valid_i),
    .accept_o     (accept),
    .complete_o   (complete),
    .op_q_o       (op_q),
    .cdi_q_o      (cdi_q),
    .hash_req_o   (hash_req_o),
    .status_o     (status),
    .op_done_o    (op_done_o)
  );

  ks_key_stage #(.KEY_W(KEY_W)) i_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .cmd_op_i    (op_e'(cmd_op_i)),
    .cmd_cdi_i   (cmd_cdi_i),
    .complete_i  (complete),
    .op_q_i      (op_q),
    .escalate_i  (escalate_i),
    .root_i      (root_i),
    .digest_i    (hash_digest_i),
    .entropy_i   (entropy_i),
    .stage_o     (stage),
    .key_o       (key),
    .hash_data_o (hash_data_o)
  );

  ks_gen_out #(.KEY_W(KEY_W)) i_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .complete_i (complete),
    .op_q_i     (op_q),
    .stage_i    (stage),
    .digest_i   (hash_digest_i),
    .entropy_i  (entropy_i),
    .ident_o    (ident_out_o),
    .sw_o       (sw_out_o)
  );

  ks_sideload #(.KEY_W(KEY_W), .NUM_DEST(NUM_DEST), .DEST_W(DEST_W)) i_sl (
    .stage_i (stage),
    .key_i   (key),
    .dest_i  (sl_dest_i),
    .valid_o (sl_valid_o),
    .key_o   (sl_key_o)
  );

  assign status_o = status;
  assign stage_o  = stage;

  logic unused_cdi;
  assign unused_cdi = cdi_q;

  assert_data_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && $past(hash_req_o) |-> $stable(hash_data_o));
  assert_gen_keeps_key_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    complete && op_q != OP_ADVANCE |=> $stable(key) && $stable(stage));
  assert_sl_dark_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage == STG_RESET || stage == STG_DISABLED) |-> sl_valid_o == '0);
  assert_reject_stage_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hash_req_o && cmd_valid_i && !hash_valid_i && !escalate_i |=> $stable(stage));
endmodule

// File: tb/test_key_stage_ctrl.sv
`timescale 1ns/1ps
module test_key_stage_ctrl;
  localparam int KEY_W = 256;
  localparam logic [KEY_W-1:0] ROOT = {8{32'h0badc0de}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_cdi = 0, escalate = 0, hash_valid = 0;
  logic [1:0] cmd_op = 0, sl_dest = 0;
  logic [KEY_W-1:0] entropy = {8{32'h13579bdf}}, digest = '0;
  logic hash_req, op_done;
  logic [KEY_W-1:0] hash_data, ident_out, sw_out, sl_key;
  logic [1:0] status;
  logic [2:0] stage;
  logic [2:0] sl_valid;

  int n_chk = 0, n_fail = 0, n_hash = 0;
  int exp_stage = 0;
  logic [KEY_W-1:0] exp_key = '0, exp_id = '0, exp_sw = '0;
  logic [KEY_W-1:0] k_hist [0:3];

  always #2.5 clk = ~clk;

  key_stage_ctrl i_key_stage_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_cdi_i(cmd_cdi), .root_i(ROOT), .escalate_i(escalate), .entropy_i(entropy),
    .hash_req_o(hash_req), .hash_data_o(hash_data), .hash_valid_i(hash_valid),
    .hash_digest_i(digest), .status_o(status), .op_done_o(op_done), .stage_o(stage),
    .ident_out_o(ident_out), .sw_out_o(sw_out), .sl_dest_i(sl_dest),
    .sl_valid_o(sl_valid), .sl_key_o(sl_key)
  );

  task automatic chk(input bit ok, input string req, input logic [KEY_W-1:0] act,
                     input logic [KEY_W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [KEY_W-1:0] salt(int s, int o, bit c);
    logic [7:0] b;
    b = {s[2:0], o[1:0], c, 2'b01};
    return {(KEY_W/8){b}};
  endfunction

  function automatic logic [KEY_W-1:0] hmodel(logic [KEY_W-1:0] d, int k);
    return {d[KEY_W-9:0], d[KEY_W-1 -: 8]} ^ {(KEY_W/32){32'h6d2b79f5 ^ k}};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    exp_stage = 0; exp_key = '0; exp_id = '0; exp_sw = '0;
  endtask

  task automatic sl_check(input string req);
    for (int d = 0; d < 4; d++) begin
      logic [2:0] ev;
      logic live;
      sl_dest = d[1:0]; #1;
      live = exp_stage >= 1 && exp_stage <= 3 && d < 3;
      ev = live ? 3'(1 << d) : 3'b000;
      chk(sl_valid == ev, req, sl_valid, ev);
      chk(sl_key == (live ? exp_key : '0), req, sl_key, live ? exp_key : '0);
    end
    sl_dest = 0; #1;
  endtask

  task automatic issue(input int op, input bit c);
    @(negedge clk); cmd_valid = 1; cmd_op = op[1:0]; cmd_cdi = c;
    @(negedge clk); cmd_valid = 0; #1;
  endtask

  task automatic err_cmd(input int op, input bit c);
    issue(op, c);
    chk(op_done == 1 && status == 2'd3, "R9 error status", status, 3);
    chk(hash_req == 0, "R9 no hash request", hash_req, 0);
    chk(stage == 3'(exp_stage), "R9 stage kept", stage, exp_stage);
    @(negedge clk); #1;
    chk(op_done == 0, "R4 single pulse", op_done, 0);
  endtask

  task automatic run_ok(input int op, input bit c, input int dly, input bit rej);
    logic [KEY_W-1:0] ed, dg;
    ed = (op == 0 && exp_stage == 0) ? ROOT : exp_key ^ salt(exp_stage, op, c);
    issue(op, c);
    chk(hash_req == 1, "R3 request raised", hash_req, 1);
    chk(hash_data == ed, "R3 hash data", hash_data, ed);
    chk(status == 2'd1, "R4 busy status", status, 1);
    if (rej) begin
      issue(0, 0);
      chk(op_done == 1 && status == 2'd3, "R8 busy reject", status, 3);
      chk(stage == 3'(exp_stage) && hash_req == 1, "R8 op continues", stage, exp_stage);
    end
    for (int i = 0; i < dly; i++) begin
      @(negedge clk); #1;
      chk(hash_req == 1 && hash_data == ed, "R3 request held", hash_data, ed);
    end
    dg = hmodel(ed, n_hash++);
    @(negedge clk); hash_valid = 1; digest = dg;
    @(negedge clk); hash_valid = 0; #1;
    chk(op_done == 1 && status == 2'd2, "R4 done success", status, 2);
    chk(hash_req == 0, "R3 request dropped", hash_req, 0);
    if (op == 0) begin
      exp_stage++;
      exp_key = (exp_stage == 4) ? entropy : dg;
      if (exp_stage < 4) k_hist[exp_stage] = dg;
    end else if (op == 1) exp_id = (exp_stage == 4) ? entropy : dg;
    else exp_sw = (exp_stage == 4) ? entropy : dg;
    chk(stage == 3'(exp_stage), "R2 stage", stage, exp_stage);
    chk(ident_out == exp_id, "R5 identity output", ident_out, exp_id);
    chk(sw_out == exp_sw, "R5 software output", sw_out, exp_sw);
    sl_check("R10 sideload");
    @(negedge clk); #1;
    chk(op_done == 0, "R4 single pulse", op_done, 0);
  endtask

  task automatic esc_pulse();
    @(negedge clk); escalate = 1;
    @(negedge clk); escalate = 0; #1;
    if (exp_stage != 4) exp_key = entropy;
    exp_stage = 4;
    chk(stage == 3'd4, "R6 escalation to disabled", stage, 4);
    sl_check("R10 dark when disabled");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    k_hist[0] = ROOT;
    do_reset();
    chk(stage == 0 && status == 0, "R1 reset state", {stage, status}, 0);
    chk(op_done == 0 && hash_req == 0, "R1 reset strobes", {op_done, hash_req}, 0);
    sl_check("R1 sideload off");
    err_cmd(1, 0);
    err_cmd(3, 0);
    run_ok(0, 0, 0, 0);
    for (int s = 1; s <= 3; s++) begin
      for (int op = 1; op <= 2; op++)
        for (int c = 0; c < 2; c++)
          run_ok(op, c[0], (op + c + s) % 4, 0);
      err_cmd(3, 1);
      run_ok(2, s[0], 1, 1);
      run_ok(0, 0, s, 0);
    end
    // disabled: outputs from entropy (R7)
    entropy = {8{32'h2468ace1}};
    run_ok(1, 0, 1, 0);
    entropy = {8{32'h9e3779b9}};
    run_ok(2, 1, 2, 0);
    chk(sw_out == entropy && ident_out == {8{32'h2468ace1}}, "R7 entropy output",
        sw_out, entropy);
    chk(sw_out != '0 && sw_out != '1 && ident_out != '0 && ident_out != '1,
        "R7 not constant", sw_out, entropy);
    for (int k = 1; k <= 3; k++)
      chk(sw_out != k_hist[k] && ident_out != k_hist[k], "R7 not a key", sw_out, k_hist[k]);
    err_cmd(0, 0);
    // escalation from every stage
    for (int s = 0; s <= 3; s++) begin
      do_reset();
      entropy = {8{32'h0f1e2d3c ^ s}};
      for (int a = 0; a < s; a++) run_ok(0, 0, 1, 0);
      esc_pulse();
      run_ok(1, 1, 0, 0);
      chk(ident_out == entropy, "R7 entropy after escalation", ident_out, entropy);
    end
    // escalation mid-operation
    do_reset();
    run_ok(0, 0, 0, 0);
    issue(2, 0);
    @(negedge clk); escalate = 1;
    @(negedge clk); escalate = 0; #1;
    chk(op_done == 1 && status == 2'd3, "R6 abort", status, 3);
    chk(hash_req == 0 && stage == 3'd4, "R6 abort disabled", stage, 4);
    @(negedge clk); hash_valid = 1; digest = '1;
    @(negedge clk); hash_valid = 0; #1;
    chk(op_done == 0 && status == 2'd3, "R6 late digest ignored", status, 3);
    chk(sw_out == '0, "R6 no output from late digest", sw_out, 0);
    summary();
  end
endmodule